// File: doc/BRIEF.md
# Buck Regulator Fault Sequencer

This block is the digital supervisor for a synchronous buck power stage. It decides when the high-side and low-side switches may operate. It moves the stage through five phases: off, soft-start, regulation, hiccup retry and thermal hold. It does this from registered samples of the following inputs:

- a feedback-voltage code
- the present soft-start reference code
- a supply-valid flag
- an enable input
- a junction-temperature code
- an overcurrent flag
- a short-circuit flag

The comparators, the modulator, the gate drivers and the reference ramp itself all sit outside the block.

All timing counts a slow tick that an internal divider derives from the clock. The soft-start length is a programmable tick count. The hiccup wait is a parameterised multiple of that count, 20 by default. Each protection is armed in its own phase:

- Overvoltage is watched as soon as the supply is valid.
- Overcurrent acts through start-up and regulation.
- Undervoltage and short circuit act only after start-up has completed.
- Temperature acts in every active phase.

Top module: `buck_fault_seq`

## Requirements
- R1: After reset, every output is 0 and the block is in the off phase.
- R2: With enable and supply-valid both high, the block enters soft-start. It pulses `ss_start_o` for one cycle and holds `ss_ramp_o` high while soft-start lasts.
- R3: During soft-start, switching is withheld whenever the feedback code is strictly greater than the soft-start reference code.
- R4: Soft-start ends after `ss_ticks_i` ticks. `ss_done_o` then rises and stays high through regulation.
- R5: When supply-valid is high and the feedback code exceeds 614 (120 % of the set-point code 512), switching stops at once and `flt_ov_o` is set. This holds in soft-start and in regulation. Both recover by themselves when the code is 614 or below.
- R6: A low feedback code during soft-start never raises an undervoltage fault.
- R7: In regulation, a feedback code below 461 must persist for more than UV_TICKS ticks before it counts. Shorter dips are ignored. Once it counts, switching stops, `ss_done_o` falls and `flt_uv_o` is set.
- R8: After an undervoltage or short-circuit fault, the block waits HICCUP_MULT × `ss_ticks_i` ticks without switching. It then starts a fresh soft-start and clears the fault bit.
- R9: A temperature code above 150 (degrees C) stops switching and sets `flt_ot_o`. A restart, through soft-start, happens only once the code is below 115.
- R10: A high overcurrent flag withholds switching during soft-start and regulation, and `flt_oc_o` follows it.
- R11: The short-circuit flag is ignored during soft-start. In regulation it starts a hiccup and sets `flt_sc_o`.
- R12: Enable low or supply-valid low stops switching one cycle after sampling. One cycle later it forces the off phase, clearing the timers, `ss_done_o` and the fault latches.
- R13: Overtemperature takes precedence over every other fault. While overvoltage is present, undervoltage and short-circuit triggers are not acted on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en_i | input | 1 | Enable request |
| uvlo_ok_i | input | 1 | Supply above lockout level |
| fb_i | input | FB_W | Sampled feedback code |
| ss_ref_i | input | FB_W | Present soft-start reference code |
| temp_i | input | TEMP_W | Junction temperature code, degrees C |
| oc_i | input | 1 | Overcurrent flag |
| sc_i | input | 1 | Short-circuit flag |
| ss_ticks_i | input | SS_W | Soft-start length in ticks |
| sw_en_o | output | 1 | Switching permit for both power switches |
| ss_start_o | output | 1 | One-cycle pulse that restarts the reference ramp |
| ss_ramp_o | output | 1 | Reference ramp command, high in soft-start |
| ss_done_o | output | 1 | Soft-start completed, regulating |
| flt_ov_o | output | 1 | Overvoltage present |
| flt_uv_o | output | 1 | Undervoltage hiccup in progress |
| flt_ot_o | output | 1 | Thermal hold |
| flt_oc_o | output | 1 | Overcurrent present |
| flt_sc_o | output | 1 | Short-circuit hiccup in progress |

## Verification
A wrong phase shows at the ports within two cycles of its cause. The phase decodes directly into `ss_ramp_o`, `ss_done_o` and `flt_ot_o`, and the permit `sw_en_o` follows it. A miscounted tick timer shows only when its window closes: early or late `ss_done_o` for soft-start, and a misplaced `ss_start_o` after a hiccup. The bench therefore brackets those edges with a lower and an upper cycle bound. The undervoltage filter is probed both sides of its limit: a dip one tick short must leave `flt_uv_o` low, and a sustained dip must raise it inside a bounded window.

// File: rtl/bfs_pkg.sv
// Package: shared phase encoding for the buck fault sequencer.
// Assumes: one phase active at a time; encoding is internal only.
package bfs_pkg;

    typedef enum logic [2:0] {
        ST_OFF     = 3'd0,
        ST_SOFT    = 3'd1,
        ST_RUN     = 3'd2,
        ST_HICCUP  = 3'd3,
        ST_THERMAL = 3'd4
    } bfs_state_t;

endpackage

// File: rtl/bfs_tick_gen.sv
// Module: free-running divider that emits a one-cycle tick every TICK_DIV
// clocks. Assumes TICK_DIV >= 1; the tick is the time base of all timers.
module bfs_tick_gen #(
    parameter int TICK_DIV = 250
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);
    localparam int CW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);

    logic [CW-1:0] cnt_q;

    // Wrap the divider count at LAST.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (cnt_q == LAST)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + 1'b1;
    end

    assign tick_o = (cnt_q == LAST);
endmodule

// File: rtl/bfs_sense.sv
// Module: one register stage that turns raw codes and flags into decided
// condition bits. Assumes inputs are already synchronous to clk; all
// threshold comparisons are strict.
module bfs_sense #(
    parameter int FB_W   = 10,
    parameter int TEMP_W = 8,
    parameter int OV_TH  = 614,
    parameter int UV_TH  = 461,
    parameter int OT_HI  = 150,
    parameter int OT_LO  = 115
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic              uvlo_ok_i,
    input  logic [FB_W-1:0]   fb_i,
    input  logic [FB_W-1:0]   ss_ref_i,
    input  logic [TEMP_W-1:0] temp_i,
    input  logic              oc_i,
    input  logic              sc_i,
    output logic              en_q,
    output logic              uvlo_q,
    output logic              ov_q,
    output logic              low_q,
    output logic              prebias_q,
    output logic              hot_q,
    output logic              cool_q,
    output logic              oc_q,
    output logic              sc_q
);
    localparam logic [FB_W-1:0]   OV_C = FB_W'(OV_TH);
    localparam logic [FB_W-1:0]   UV_C = FB_W'(UV_TH);
    localparam logic [TEMP_W-1:0] HI_C = TEMP_W'(OT_HI);
    localparam logic [TEMP_W-1:0] LO_C = TEMP_W'(OT_LO);

    // Register every decided condition so the phase logic sees one sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q      <= 1'b0;
            uvlo_q    <= 1'b0;
            ov_q      <= 1'b0;
            low_q     <= 1'b0;
            prebias_q <= 1'b0;
            hot_q     <= 1'b0;
            cool_q    <= 1'b0;
            oc_q      <= 1'b0;
            sc_q      <= 1'b0;
        end else begin
            en_q      <= en_i;
            uvlo_q    <= uvlo_ok_i;
            ov_q      <= uvlo_ok_i && (fb_i > OV_C);
            low_q     <= (fb_i < UV_C);
            prebias_q <= (fb_i > ss_ref_i);
            hot_q     <= (temp_i > HI_C);
            cool_q    <= (temp_i < LO_C);
            oc_q      <= oc_i;
            sc_q      <= sc_i;
        end
    end
endmodule

// File: rtl/bfs_interval_timer.sv
// Module: tick-driven down counter shared by the soft-start and hiccup
// windows. Assumes load has priority; expired is high while the count is 0.
module bfs_interval_timer #(
    parameter int CNT_W = 17
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    output logic             expired_o
);
    logic [CNT_W-1:0] cnt_q;

    // Load a new window or count one tick down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load_i)
            cnt_q <= load_val_i;
        else if (tick_i && (cnt_q != '0))
            cnt_q <= cnt_q - 1'b1;
    end

    assign expired_o = (cnt_q == '0);
endmodule

// File: rtl/bfs_uv_filter.sv
// Module: qualifies a low-feedback condition. It trips only after the
// condition has held for more than UV_TICKS ticks while armed. Assumes
// disarming or any good sample restarts the count.
module bfs_uv_filter #(
    parameter int UV_TICKS = 25
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic arm_i,
    input  logic low_i,
    output logic trip_o
);
    localparam int CW = $clog2(UV_TICKS + 2);
    localparam logic [CW-1:0] LIM = CW'(UV_TICKS + 1);

    logic [CW-1:0] cnt_q;

    // Count ticks of continuous low feedback, saturating at the trip level.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (!arm_i || !low_i)
            cnt_q <= '0;
        else if (tick_i && (cnt_q != LIM))
            cnt_q <= cnt_q + 1'b1;
    end

    assign trip_o = (cnt_q == LIM);
endmodule

// File: rtl/buck_fault_seq.sv
// Module: top of the buck fault sequencer. It sequences off, soft-start,
// regulation, hiccup and thermal hold, and forms the switching permit.
// Assumes: inputs synchronous to clk; ss_ticks_i stable while active.
module buck_fault_seq
    import bfs_pkg::*;
#(
    parameter int FB_W        = 10,
    parameter int TEMP_W      = 8,
    parameter int SS_W        = 12,
    parameter int TICK_DIV    = 250,
    parameter int UV_TICKS    = 25,
    parameter int HICCUP_MULT = 20,
    parameter int OV_TH       = 614,
    parameter int UV_TH       = 461,
    parameter int OT_HI       = 150,
    parameter int OT_LO       = 115
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic              uvlo_ok_i,
    input  logic [FB_W-1:0]   fb_i,
    input  logic [FB_W-1:0]   ss_ref_i,
    input  logic [TEMP_W-1:0] temp_i,
    input  logic              oc_i,
    input  logic              sc_i,
    input  logic [SS_W-1:0]   ss_ticks_i,
    output logic              sw_en_o,
    output logic              ss_start_o,
    output logic              ss_ramp_o,
    output logic              ss_done_o,
    output logic              flt_ov_o,
    output logic              flt_uv_o,
    output logic              flt_ot_o,
    output logic              flt_oc_o,
    output logic              flt_sc_o
);
    localparam int CNT_W = SS_W + $clog2(HICCUP_MULT + 1);
    localparam logic [CNT_W-1:0] MULT_C = CNT_W'(HICCUP_MULT);

    logic tick;
    logic en_q, uvlo_q, ov_q, low_q, prebias_q, hot_q, cool_q, oc_q, sc_q;
    logic tmr_load, tmr_expired, uv_trip;
    logic [CNT_W-1:0] tmr_val;
    bfs_state_t state_q, state_d;
    logic flt_uv_q, flt_sc_q, ss_start_q;
    logic to_hiccup;

    bfs_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
        .clk(clk), .rst_n(rst_n), .tick_o(tick)
    );

    bfs_sense #(
        .FB_W(FB_W), .TEMP_W(TEMP_W), .OV_TH(OV_TH), .UV_TH(UV_TH),
        .OT_HI(OT_HI), .OT_LO(OT_LO)
    ) u_sense (
        .clk(clk), .rst_n(rst_n), .en_i(en_i), .uvlo_ok_i(uvlo_ok_i),
        .fb_i(fb_i), .ss_ref_i(ss_ref_i), .temp_i(temp_i), .oc_i(oc_i),
        .sc_i(sc_i), .en_q(en_q), .uvlo_q(uvlo_q), .ov_q(ov_q),
        .low_q(low_q), .prebias_q(prebias_q), .hot_q(hot_q),
        .cool_q(cool_q), .oc_q(oc_q), .sc_q(sc_q)
    );

    bfs_interval_timer #(.CNT_W(CNT_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .load_i(tmr_load),
        .load_val_i(tmr_val), .expired_o(tmr_expired)
    );

    bfs_uv_filter #(.UV_TICKS(UV_TICKS)) u_uvf (
        .clk(clk), .rst_n(rst_n), .tick_i(tick),
        .arm_i(state_q == ST_RUN), .low_i(low_q), .trip_o(uv_trip)
    );

    // Regulation fault that starts a hiccup; overvoltage masks it.
    assign to_hiccup = (state_q == ST_RUN) && !ov_q && (uv_trip || sc_q);

    // Next-phase decision; thermal first, then supply/enable override.
    always_comb begin
        state_d = state_q;
        if (!en_q || !uvlo_q) begin
            state_d = ST_OFF;
        end else begin
            unique case (state_q)
                ST_OFF:     state_d = hot_q ? ST_THERMAL : ST_SOFT;
                ST_SOFT:    if (hot_q)            state_d = ST_THERMAL;
                            else if (tmr_expired) state_d = ST_RUN;
                ST_RUN:     if (hot_q)            state_d = ST_THERMAL;
                            else if (to_hiccup)   state_d = ST_HICCUP;
                ST_HICCUP:  if (hot_q)            state_d = ST_THERMAL;
                            else if (tmr_expired) state_d = ST_SOFT;
                ST_THERMAL: if (cool_q)           state_d = ST_SOFT;
                default:    state_d = ST_OFF;
            endcase
        end
    end

    // Timer window: reload on every phase change, hold cleared while off.
    always_comb begin
        tmr_load = (state_d != state_q) || (state_d == ST_OFF);
        if (state_d == ST_HICCUP)
            tmr_val = CNT_W'(ss_ticks_i) * MULT_C;
        else if (state_d == ST_SOFT)
            tmr_val = CNT_W'(ss_ticks_i);
        else
            tmr_val = '0;
    end

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_OFF;
        else
            state_q <= state_d;
    end

    // Hiccup cause latches: set on entry, held only while in hiccup.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flt_uv_q <= 1'b0;
            flt_sc_q <= 1'b0;
        end else if (state_d != ST_HICCUP) begin
            flt_uv_q <= 1'b0;
            flt_sc_q <= 1'b0;
        end else if (state_q == ST_RUN) begin
            flt_uv_q <= uv_trip;
            flt_sc_q <= sc_q;
        end
    end

    // Ramp restart pulse on every entry into soft-start.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ss_start_q <= 1'b0;
        else
            ss_start_q <= (state_d == ST_SOFT) && (state_q != ST_SOFT);
    end

    // Switching permit: allowed phase, no blocking condition present.
    assign sw_en_o = en_q && uvlo_q && !ov_q && !oc_q &&
                     (((state_q == ST_SOFT) && !prebias_q) || (state_q == ST_RUN));

    assign ss_start_o = ss_start_q;
    assign ss_ramp_o  = (state_q == ST_SOFT);
    assign ss_done_o  = (state_q == ST_RUN);
    assign flt_ov_o   = ov_q;
    assign flt_uv_o   = flt_uv_q;
    assign flt_ot_o   = (state_q == ST_THERMAL);
    assign flt_oc_o   = oc_q;
    assign flt_sc_o   = flt_sc_q;
endmodule

// File: rtl/bfs_checker.sv
// Module: temporal properties of the fault sequencer, seen through its
// ports. Assumes it is attached by the bind below and shares parameters.
module bfs_checker #(
    parameter int FB_W   = 10,
    parameter int TEMP_W = 8,
    parameter int OV_TH  = 614,
    parameter int OT_HI  = 150
) (
    input logic              clk,
    input logic              rst_n,
    input logic              en_i,
    input logic              uvlo_ok_i,
    input logic [FB_W-1:0]   fb_i,
    input logic [TEMP_W-1:0] temp_i,
    input logic              sw_en_o,
    input logic              ss_start_o,
    input logic              ss_ramp_o,
    input logic              ss_done_o,
    input logic              flt_uv_o
);
    // Entering soft-start always drives the ramp command.
    assert_start_ramps_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ss_start_o |-> ss_ramp_o);

    // Completion is reached only from a soft-start phase.
    assert_done_after_ramp_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ss_done_o) |-> $past(ss_ramp_o));

    // Overvoltage blocks switching on the following cycle.
    assert_ov_blocks_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (uvlo_ok_i && (fb_i > FB_W'(OV_TH))) |=> !sw_en_o);

    // An undervoltage hiccup only follows completed soft-start.
    assert_uv_after_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flt_uv_o) |-> $past(ss_done_o));

    // Overheating stops switching within two cycles.
    assert_hot_stops_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (temp_i > TEMP_W'(OT_HI)) |-> ##2 !sw_en_o);

    // Dropping enable stops switching on the following cycle.
    assert_disable_stops_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> !sw_en_o);
endmodule

bind buck_fault_seq bfs_checker #(
    .FB_W(FB_W), .TEMP_W(TEMP_W), .OV_TH(OV_TH), .OT_HI(OT_HI)
) u_bfs_checker (
    .clk(clk), .rst_n(rst_n), .en_i(en_i), .uvlo_ok_i(uvlo_ok_i),
    .fb_i(fb_i), .temp_i(temp_i), .sw_en_o(sw_en_o),
    .ss_start_o(ss_start_o), .ss_ramp_o(ss_ramp_o),
    .ss_done_o(ss_done_o), .flt_uv_o(flt_uv_o)
);

// File: tb/buck_fault_seq_bench.sv
module buck_fault_seq_bench;
    localparam int DIV   = 4;
    localparam int UVT   = 5;
    localparam int MULT  = 20;
    localparam int SST   = 10;
    localparam int OV    = 614;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en = 1'b0, uvlo = 1'b0, oc = 1'b0, sc = 1'b0;
    logic [9:0] fb = '0, ss_ref = '0;
    logic [7:0] temp = 8'd25;
    logic [11:0] ss_ticks = 12'(SST);
    logic sw_en, ss_start, ss_ramp, ss_done;
    logic f_ov, f_uv, f_ot, f_oc, f_sc;
    int tests = 0, fails = 0;

    always #2 clk = ~clk;

    buck_fault_seq #(
        .TICK_DIV(DIV), .UV_TICKS(UVT), .HICCUP_MULT(MULT)
    ) u_buck_fault_seq (
        .clk(clk), .rst_n(rst_n), .en_i(en), .uvlo_ok_i(uvlo), .fb_i(fb),
        .ss_ref_i(ss_ref), .temp_i(temp), .oc_i(oc), .sc_i(sc),
        .ss_ticks_i(ss_ticks), .sw_en_o(sw_en), .ss_start_o(ss_start),
        .ss_ramp_o(ss_ramp), .ss_done_o(ss_done), .flt_ov_o(f_ov),
        .flt_uv_o(f_uv), .flt_ot_o(f_ot), .flt_oc_o(f_oc), .flt_sc_o(f_sc)
    );

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_sw(input int f, input int o);
        return (f > OV || o != 0) ? 0 : 1;
    endfunction

    task automatic wait_done(input string req);
        int n = 0;
        while (!ss_done && n < 200) begin step(1); n++; end
        check(req, int'(ss_done), 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int n;
        bit bad;
        void'($urandom(32'd4242));
        step(5);
        rst_n = 1'b1;
        step(1);
        // R1 reset state
        check("R1 sw_en", int'(sw_en), 0);
        check("R1 outputs", int'({ss_start, ss_ramp, ss_done, f_ov, f_uv, f_ot, f_oc, f_sc}), 0);

        // R2 start
        en = 1; uvlo = 1; fb = 0; ss_ref = 0;
        step(2);
        check("R2 ss_start", int'(ss_start), 1);
        check("R2 ss_ramp", int'(ss_ramp), 1);
        check("R3 no prebias", int'(sw_en), 1);
        // R3 pre-bias
        fb = 300; ss_ref = 200; step(1);
        check("R3 prebias blocks", int'(sw_en), 0);
        ss_ref = 400; step(1);
        check("R3 below ramp", int'(sw_en), 1);
        // R6 low feedback during soft-start
        fb = 100; ss_ref = 1023;
        step(31);
        check("R4 not yet done", int'(ss_done), 0);
        fb = 512;
        step(7);
        check("R4 done", int'(ss_done), 1);
        check("R6 no uv in soft-start", int'(f_uv), 0);

        // R5 overvoltage in regulation
        fb = 700; step(1);
        check("R5 ov blocks", int'(sw_en), 0);
        check("R5 flt_ov", int'(f_ov), 1);
        fb = 512; step(1);
        check("R5 recovers", int'(sw_en), 1);
        // R10 overcurrent
        oc = 1; step(1);
        check("R10 oc blocks", int'(sw_en), 0);
        check("R10 flt_oc", int'(f_oc), 1);
        oc = 0; step(1);
        check("R10 recovers", int'(sw_en), 1);

        // random mix in regulation (R5, R10, R7 short dips)
        for (int i = 0; i < 150; i++) begin
            int r = int'($urandom % 4);
            int f;
            int o = ($urandom % 4 == 0) ? 1 : 0;
            if (r == 0) f = 480 + int'($urandom % 121);
            else if (r == 1) f = 615 + int'($urandom % 409);
            else if (r == 2) f = int'($urandom % 400);
            else f = OV;
            fb = 10'(f); oc = o[0];
            step(1);
            check("R5 random sw_en", int'(sw_en), exp_sw(f, o));
            check("R5 random flt_ov", int'(f_ov), (f > OV) ? 1 : 0);
            fb = 512; oc = 0;
            step(1);
        end
        step(2);
        check("R7 random dips ignored", int'(ss_done), 1);

        // R7 short dip
        fb = 100; step((UVT - 1) * DIV);
        fb = 512; step(2);
        check("R7 short dip", int'(f_uv), 0);
        check("R7 short dip done", int'(ss_done), 1);
        // R7 long dip
        fb = 100; n = 0;
        while (!f_uv && n < 60) begin step(1); n++; end
        fb = 512;
        check("R7 uv raised", int'(f_uv), 1);
        check("R7 filter low bound", int'(n >= UVT * DIV), 1);
        check("R7 filter high bound", int'(n <= (UVT + 1) * DIV + 3), 1);
        check("R7 done cleared", int'(ss_done), 0);
        // R8 hiccup window
        n = 0; bad = 0;
        while (!ss_start && n < 1000) begin
            if (sw_en) bad = 1;
            step(1); n++;
        end
        check("R8 no switching in hiccup", int'(bad), 0);
        check("R8 hiccup low bound", int'(n >= SST * MULT * DIV - 4), 1);
        check("R8 hiccup high bound", int'(n <= SST * MULT * DIV + 4), 1);
        check("R8 uv bit cleared", int'(f_uv), 0);

        // R11 short circuit ignored in soft-start
        sc = 1; step(20);
        check("R11 sc ignored in ss", int'(f_sc), 0);
        check("R11 still ramping", int'(ss_ramp), 1);
        sc = 0;
        wait_done("R11 reach run");
        sc = 1; step(2);
        check("R11 sc hiccup", int'(f_sc), 1);
        check("R11 sc stops switching", int'(sw_en), 0);
        sc = 0;
        // R12 disable during hiccup
        en = 0; step(2);
        check("R12 off clears sc", int'(f_sc), 0);
        check("R12 off no ramp", int'(ss_ramp), 0);
        en = 1;
        wait_done("R12 restart");
        // R12 supply loss
        uvlo = 0; step(1);
        check("R12 uvlo stops sw", int'(sw_en), 0);
        step(1);
        check("R12 uvlo clears done", int'(ss_done), 0);
        uvlo = 1;
        wait_done("R12 restart after uvlo");

        // R9 thermal
        temp = 150; step(3);
        check("R9 150 not hot", int'(ss_done), 1);
        temp = 160; step(2);
        check("R9 hot", int'(f_ot), 1);
        check("R9 hot stops sw", int'(sw_en), 0);
        temp = 130; step(20);
        check("R9 hysteresis hold", int'(f_ot), 1);
        temp = 115; step(5);
        check("R9 115 still held", int'(f_ot), 1);
        temp = 114; step(2);
        check("R9 cooled", int'(f_ot), 0);
        check("R9 restart via ss", int'(ss_start), 1);
        // R5 overvoltage during soft-start
        fb = 700; step(1);
        check("R5 ov in ss", int'(f_ov), 1);
        check("R5 ov in ss blocks", int'(sw_en), 0);
        fb = 512; step(1);
        check("R5 ss recovers", int'(sw_en), 1);
        wait_done("R9 back to run");

        // R13 priorities
        temp = 160; sc = 1; step(2);
        check("R13 ot wins", int'(f_ot), 1);
        check("R13 sc not latched", int'(f_sc), 0);
        temp = 25; sc = 0;
        wait_done("R13 restart");
        fb = 700; sc = 1; step(3);
        check("R13 ov masks sc", int'(f_sc), 0);
        check("R13 stays run", int'(ss_done), 1);
        check("R13 no switching", int'(sw_en), 0);
        sc = 0; fb = 512; step(2);
        check("R13 resume", int'(sw_en), 1);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule